// File: doc/BRIEF.md
# Four-Port LED PWM Dimmer with Blink Gating

This block drives the current-sink enables of four LED ports. Each port has an 8-bit brightness ratio of its own, and one common ratio is shared by all four. A per-port configuration byte picks which of the two ratios the port follows. The same byte can also turn on a slow blink, which forces the LED off for part of a longer period. Each port runs a free-running 256-step PWM counter. The ratio in use is captured into a shadow copy only when that counter wraps, so a change never cuts a PWM period short or stretches it.

A shared prescaler divides the clock into millisecond ticks, and a 12-bit millisecond counter provides the blink phase. Software-side writes arrive on a single-cycle strobe with a 4-bit address and a byte of data. Every output is registered.

Top module: `led_pwm_blink`

## Requirements
- R1: Each port's PWM counter advances by one every clock and wraps after 256 steps, so one PWM period is 256 clocks.
- R2: A latched ratio N in 0x00..0xFE drives the port high for exactly N clocks of every 256, and a ratio of 0x00 keeps it low.
- R3: A latched ratio of 0xFF drives the port high on every clock while blinking allows it.
- R4: Address 0x1 writes the common ratio, address 0x8+p writes port p's individual ratio, and address 0xC+p writes port p's configuration byte. Bit 5 of the configuration byte set to 1 selects the common ratio and set to 0 selects the individual ratio.
- R5: A new ratio value or a new source selection takes effect only when the PWM counter wraps from 255 to 0. The PWM period already running keeps its old on-time.
- R6: One write to the common ratio changes the brightness of every port whose configuration selects the common source.
- R7: Configuration bits [4:2] hold the blink code. Code 0 disables blinking. Codes 3..7 give a blink period of 256 ms × 2^(code−3), up to 4096 ms. Codes 1 and 2 behave as code 3.
- R8: Configuration bits [1:0] set the blink on-fraction: 0 gives 1/8, 1 gives 1/4, 2 gives 1/2 and 3 gives 3/4 of the blink period. The port is held low for the rest of the period, and PWM gating applies within the on-part.
- R9: Synchronous reset clears all ratios, configurations, counters and shadow ratios, and drives every output low.
- R10: One millisecond equals CYC_PER_MS clocks. Blink periods and on-times scale with that setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| led_o | output | NUM_PORTS | Registered current-sink enable, one bit per port |

## Verification
The assertions check several relations on every cycle. The counter must step by one each clock. The shadow ratio may move only on the cycle after the counter reads 255. A shadow ratio of zero forces the output low, and 0xFF with an open blink gate forces it high. A closed blink gate always forces the output low. Other behaviours are visible only through the bench's scenarios, which count high cycles over whole periods. These are the exact on-count for each ratio, the common-versus-individual selection through the address map, a write landing mid-period while the running period keeps its length, and the blink period and on-fraction for each code, including the clamped codes.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

  localparam int MS_W = 12;

  localparam logic [3:0] ADDR_COMMON     = 4'h1;
  localparam logic [3:0] ADDR_RATIO_BASE = 4'h8;
  localparam logic [3:0] ADDR_CFG_BASE   = 4'hC;

  typedef struct packed {
    logic [1:0] spare;
    logic       use_common;
    logic [2:0] blink_code;
    logic [1:0] blink_duty;
  } port_cfg_t;

  // Blink gate: high while the millisecond phase sits in the on-part.
  function automatic logic blink_open(input logic [2:0] code,
                                      input logic [1:0] duty,
                                      input logic [MS_W-1:0] ms);
    logic [MS_W:0] period;
    logic [MS_W:0] on_len;
    logic [MS_W:0] phase;
    logic [3:0]    eff;
    if (code == 3'd0) return 1'b1;
    eff    = (code < 3'd3) ? 4'd3 : {1'b0, code};
    period = (MS_W+1)'(1) << (eff + 4'd5);
    phase  = {1'b0, ms} & (period - 1'b1);
    case (duty)
      2'd0:    on_len = period >> 3;
      2'd1:    on_len = period >> 2;
      2'd2:    on_len = period >> 1;
      default: on_len = period - (period >> 2);
    endcase
    return phase < on_len;
  endfunction

endpackage

// File: rtl/led_pwm_timebase.sv
module led_pwm_timebase #(
  parameter int CYC_PER_MS = 50000,
  parameter int MS_W       = 12
) (
  input  logic            clk,
  input  logic            rst,
  output logic [MS_W-1:0] ms_o
);
  localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      ms_o  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) ms_o <= ms_o + 1'b1;
    end
  end
endmodule

// File: rtl/led_pwm_regs.sv
module led_pwm_regs
  import led_pwm_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int RATIO_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [3:0]                        wr_addr,
  input  logic [7:0]                        wr_data,
  output logic [RATIO_W-1:0]                common_o,
  output logic [NUM_PORTS-1:0][RATIO_W-1:0] ratio_o,
  output port_cfg_t [NUM_PORTS-1:0]         cfg_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      common_o <= '0;
      ratio_o  <= '0;
      cfg_o    <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_COMMON) common_o <= wr_data[RATIO_W-1:0];
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wr_addr == ADDR_RATIO_BASE + 4'(p)) ratio_o[p] <= wr_data[RATIO_W-1:0];
        if (wr_addr == ADDR_CFG_BASE + 4'(p))   cfg_o[p]   <= port_cfg_t'(wr_data);
      end
    end
  end
endmodule

// File: rtl/led_pwm_channel.sv
module led_pwm_channel #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               use_common,
  input  logic [RATIO_W-1:0] common_ratio,
  input  logic [RATIO_W-1:0] own_ratio,
  input  logic               gate,
  output logic               led_o,
  output logic [RATIO_W-1:0] cnt_o,
  output logic [RATIO_W-1:0] shadow_o
);
  localparam logic [RATIO_W-1:0] FULL = '1;

  logic [RATIO_W-1:0] sel_ratio;
  logic               pwm_hi;

  assign sel_ratio = use_common ? common_ratio : own_ratio;
  assign pwm_hi    = (shadow_o == FULL) || (cnt_o < shadow_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      shadow_o <= '0;
      led_o    <= 1'b0;
    end else begin
      cnt_o <= cnt_o + 1'b1;
      if (cnt_o == FULL) shadow_o <= sel_ratio;
      led_o <= pwm_hi && gate;
    end
  end
endmodule

// File: rtl/led_pwm_blink.sv
module led_pwm_blink
  import led_pwm_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int RATIO_W    = 8,
  parameter int CYC_PER_MS = 50000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [3:0]           wr_addr,
  input  logic [7:0]           wr_data,
  output logic [NUM_PORTS-1:0] led_o
);
  logic [RATIO_W-1:0]                common_ratio;
  logic [NUM_PORTS-1:0][RATIO_W-1:0] own_ratio;
  port_cfg_t [NUM_PORTS-1:0]         cfg;
  logic [MS_W-1:0]                   ms_now;
  logic [NUM_PORTS-1:0]              ch_gate;
  logic [NUM_PORTS-1:0][RATIO_W-1:0] ch_cnt;
  logic [NUM_PORTS-1:0][RATIO_W-1:0] ch_shadow;

  led_pwm_regs #(.NUM_PORTS(NUM_PORTS), .RATIO_W(RATIO_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .common_o(common_ratio), .ratio_o(own_ratio), .cfg_o(cfg)
  );

  led_pwm_timebase #(.CYC_PER_MS(CYC_PER_MS), .MS_W(MS_W)) u_time (
    .clk(clk), .rst(rst), .ms_o(ms_now)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign ch_gate[p] = blink_open(cfg[p].blink_code, cfg[p].blink_duty, ms_now);

    led_pwm_channel #(.RATIO_W(RATIO_W)) u_ch (
      .clk(clk), .rst(rst),
      .use_common(cfg[p].use_common),
      .common_ratio(common_ratio),
      .own_ratio(own_ratio[p]),
      .gate(ch_gate[p]),
      .led_o(led_o[p]),
      .cnt_o(ch_cnt[p]),
      .shadow_o(ch_shadow[p])
    );
  end
endmodule

// File: rtl/led_pwm_blink_chk.sv
module led_pwm_blink_chk #(
  parameter int NUM_PORTS = 4,
  parameter int RATIO_W   = 8
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NUM_PORTS-1:0]              led_o,
  input logic [NUM_PORTS-1:0]              gate,
  input logic [NUM_PORTS-1:0][RATIO_W-1:0] cnt,
  input logic [NUM_PORTS-1:0][RATIO_W-1:0] shadow
);
  localparam logic [RATIO_W-1:0] FULL = '1;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (led_o[g] == 1'b0 && cnt[g] == '0 && shadow[g] == '0)); // R9
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
      !rst |=> cnt[g] == RATIO_W'($past(cnt[g]) + 1'b1)); // R1
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      (cnt[g] != FULL) |=> $stable(shadow[g])); // R5
    AST_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
      (shadow[g] == '0) |=> !led_o[g]); // R2
    AST_PAST_RATIO_OFF: assert property (@(posedge clk) disable iff (rst)
      (shadow[g] != FULL && cnt[g] >= shadow[g]) |=> !led_o[g]); // R2
    AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
      (shadow[g] == FULL && gate[g]) |=> led_o[g]); // R3
    AST_BLINK_OFF: assert property (@(posedge clk) disable iff (rst)
      !gate[g] |=> !led_o[g]); // R8
  end
endmodule

bind led_pwm_blink led_pwm_blink_chk #(.NUM_PORTS(NUM_PORTS), .RATIO_W(RATIO_W)) u_chk (
  .clk(clk), .rst(rst), .led_o(led_o), .gate(ch_gate), .cnt(ch_cnt), .shadow(ch_shadow)
);

// File: tb/led_pwm_blink_bench.sv
module led_pwm_blink_bench;
  localparam int NP = 4;
  localparam int CPM = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [NP-1:0] led_o;

  int checks = 0;
  int failures = 0;
  int hi [NP];

  led_pwm_blink #(.NUM_PORTS(NP), .RATIO_W(8), .CYC_PER_MS(CPM)) u_led_pwm_blink (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .led_o(led_o)
  );

  always #10 clk = ~clk;

  // {use_common[25], own ratio[24:17], common ratio[16:9], expected high count[8:0]}
  localparam logic [25:0] VEC [8] = '{
    {1'b0, 8'h00, 8'h55, 9'd0},
    {1'b0, 8'h01, 8'h00, 9'd1},
    {1'b0, 8'h80, 8'h00, 9'd128},
    {1'b0, 8'hFE, 8'h00, 9'd254},
    {1'b0, 8'hFF, 8'h00, 9'd256},
    {1'b1, 8'h10, 8'h40, 9'd64},
    {1'b1, 8'h80, 8'hFF, 9'd256},
    {1'b0, 8'h33, 8'hFF, 9'd51}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int len);
    for (int p = 0; p < NP; p++) hi[p] = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) if (led_o[p]) hi[p]++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Wait for a rising edge on port 0, optionally write at that edge, return the high run length.
  task automatic run_after_rise(input logic do_wr, input logic [3:0] a,
                                input logic [7:0] d, output int run);
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!prev && led_o[0]) break;
      prev = led_o[0];
    end
    run = 1;
    if (do_wr) begin
      wr_en = 1'b1; wr_addr = a; wr_data = d;
    end
    forever begin
      @(negedge clk);
      wr_en = 1'b0;
      if (!led_o[0]) break;
      run++;
    end
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int run;
    idle(3);
    chk("R9 output low in reset", int'(led_o), 0);
    rst = 1'b0;
    measure(300);
    chk("R9 registers cleared, no port lights", hi[0] + hi[1] + hi[2] + hi[3], 0);

    // Vector table: port 0 ratio and source selection, blinking off (R2 R3 R4 R6 R1)
    for (int v = 0; v < 8; v++) begin
      wr(4'h1, VEC[v][16:9]);
      wr(4'h8, VEC[v][24:17]);
      wr(4'hC, {2'b00, VEC[v][25], 5'b00000});
      idle(600);
      measure(256);
      chk($sformatf("R2/R3/R4 vector %0d port0 high count per 256", v), hi[0], int'(VEC[v][8:0]));
    end

    // R6: all ports on common source, one common write changes all
    for (int p = 0; p < NP; p++) begin
      wr(4'h8 + 4'(p), 8'(8'h11 * (p + 1)));
      wr(4'hC + 4'(p), 8'h20);
    end
    wr(4'h1, 8'h40);
    idle(600);
    measure(256);
    for (int p = 0; p < NP; p++) chk($sformatf("R6 port%0d common 0x40", p), hi[p], 64);
    wr(4'h1, 8'hC0);
    idle(600);
    measure(256);
    for (int p = 0; p < NP; p++) chk($sformatf("R6 port%0d common 0xC0", p), hi[p], 192);

    // R5: mid-period changes wait for the wrap
    wr(4'hC, 8'h00);
    wr(4'h8, 8'h80);
    wr(4'h1, 8'h30);
    idle(600);
    run_after_rise(1'b1, 4'h8, 8'h10, run);
    chk("R5 running period keeps old ratio", run, 128);
    run_after_rise(1'b1, 4'hC, 8'h20, run);
    chk("R5 new own ratio after wrap; source switch pending", run, 16);
    run_after_rise(1'b0, 4'h0, 8'h00, run);
    chk("R5 common source applied after wrap", run, 48);

    // R7 R8 R10: blink with full ratio, ms = CPM clocks
    wr(4'h8, 8'hFF);
    wr(4'hC, {3'b000, 3'd3, 2'd2});
    idle(600);
    measure(512);
    chk("R7 code3 period 256ms duty 1/2", hi[0], 256);
    wr(4'hC, {3'b000, 3'd1, 2'd2});
    idle(600);
    measure(512);
    chk("R7 code1 clamped to 256ms", hi[0], 256);
    wr(4'hC, {3'b000, 3'd4, 2'd0});
    idle(1100);
    measure(1024);
    chk("R8 code4 duty 1/8", hi[0], 128);
    wr(4'hC, {3'b000, 3'd3, 2'd3});
    idle(600);
    measure(512);
    chk("R8 code3 duty 3/4", hi[0], 384);
    wr(4'hC, {3'b000, 3'd7, 2'd1});
    idle(8300);
    measure(8192);
    chk("R10 code7 4096ms period duty 1/4", hi[0], 2048);
    wr(4'h8, 8'h80);
    wr(4'hC, {3'b000, 3'd3, 2'd2});
    idle(600);
    measure(512);
    chk("R8 blink combined with PWM 0x80", hi[0], 128);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule